// File: doc/BRIEF.md
# Audio Serial Transmitter (Right-Justified / I2S)

This block is the sending side of a two-channel audio serial link in which the far end is the clock master. It receives a bit clock and an LR (word-select) clock and turns a pair of parallel samples, one left and one right, into a single serial data line. Both clocks are oversampled by the block's own system clock. The data line changes only in response to a falling bit-clock edge, so a receiver can capture it on the next rising edge.

A mode input chooses between two framings. Right-justified framing ends each word on the last bit slot before the LR edge and sends the left sample while LR is high. I2S framing starts each word one bit slot after the LR edge and sends the left sample while LR is low. A two-bit code sets the word length to 16, 20, 24 or 32 bits. Words are sent MSB first. A shorter word is taken from the low bits of the 32-bit sample input.

For right-justified framing the block needs to know how many bit slots one LR half holds. It counts the slots of the previous half and uses that count. Both samples are captured together when a left half begins, so the two channels sent in one frame always belong together.

Top module: `audtx_serial_tx`

## Requirements
- R1: After reset `sdout` is 0. It stays 0 until the first LR level change after reset is seen at a falling bit-clock edge.
- R2: `sdout` changes only as the result of a falling bit-clock edge. Between falling edges it holds its value.
- R3: Slot 0 of a half is the falling edge at which the new LR level is first seen. With `fmt_i2s`=1, the MSB of the word goes out in slot 1, and the remaining bits follow MSB first in slots 2 up to the word length.
- R4: With `fmt_i2s`=1, the left sample is sent while LR is 0 and the right sample while LR is 1.
- R5: With `fmt_i2s`=0 and a half length of N slots, the LSB goes out in slot N-1, the last slot before the next LR change. The MSB goes out in slot N minus the word length.
- R6: With `fmt_i2s`=0, the left sample is sent while LR is 1 and the right sample while LR is 0.
- R7: `wl_sel` codes 0, 1, 2 and 3 select word lengths of 16, 20, 24 and 32 bits. A word of W bits is taken from bits W-1..0 of the sample input.
- R8: In every slot outside the active word, `sdout` is 0.
- R9: Both `left_in` and `right_in` are captured at the falling edge that starts a left half. Changes to them at any other time have no effect until the next left half starts.
- R10: N is the slot count of the half just before the current one. Until one full half has been counted after sync, or whenever N is less than the word length, right-justified output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples both serial clocks |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Bit clock from the link master |
| lrclk | input | 1 | LR (word select) clock from the link master |
| fmt_i2s | input | 1 | 1 = I2S framing, 0 = right-justified framing |
| wl_sel | input | 2 | Word length code: 0=16, 1=20, 2=24, 3=32 bits |
| left_in | input | 32 | Left sample, LSB aligned |
| right_in | input | 32 | Right sample, LSB aligned |
| sdout | output | 1 | Serial data, updated after falling bit-clock edges |

## Verification
Each half frame is captured slot by slot and compared with a model, using patterns chosen so that a misplaced bit shows up. I2S is run with 16-, 24- and 32-bit words in halves of 25 and 32 slots. This shows whether the MSB starts in slot 1 or slot 0, whether the word is cut short when it does not fit, and whether slots past the word stay low. Right-justified framing is run with a half longer than the word, with a half exactly as long as the word (MSB in slot 0), and with a half shorter than the word. These tell correct end alignment apart from an off-by-one in the start slot and from output sent without a valid count. The inputs are also changed in the middle of left and right halves, which separates capture at the start of a left half from following the live inputs.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

  // Which slot of the half carries which bit, if any
  typedef struct packed {
    logic       act;
    logic [7:0] pos;
  } slot_pick_t;

  // Word length code to number of bits
  function automatic int wl_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

  // Slot-to-bit mapping. I2S starts at slot 1; right-justified ends at half_len-1.
  function automatic slot_pick_t pick_bit(input logic i2s, input int slot,
                                          input int half_len, input int wl);
    slot_pick_t r;
    int first;
    int k;
    r     = '0;
    first = i2s ? 1 : half_len - wl;
    k     = slot - first;
    if ((i2s || half_len >= wl) && k >= 0 && k < wl) begin
      r.act = 1'b1;
      r.pos = 8'(wl - 1 - k);
    end
    return r;
  endfunction

endpackage

// File: rtl/audtx_edge.sv
module audtx_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic lrclk,
  output logic fall,
  output logic lr_s
);
  logic [SYNC-1:0] b_sh;
  logic [SYNC-1:0] l_sh;
  logic            b_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_sh   <= '1;
      l_sh   <= '0;
      b_last <= 1'b1;
    end else begin
      b_sh   <= {b_sh[SYNC-2:0], bclk};
      l_sh   <= {l_sh[SYNC-2:0], lrclk};
      b_last <= b_sh[SYNC-1];
    end
  end

  assign fall = b_last & ~b_sh[SYNC-1];
  assign lr_s = l_sh[SYNC-1];

  AST_FALL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R2

endmodule

// File: rtl/audtx_frame.sv
module audtx_frame #(
  parameter int SLOT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              lr_s,
  output logic              flip,
  output logic              in_sync,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [SLOT_W-1:0] half_len
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic              lr_last;
  logic              synced_r;
  logic [SLOT_W-1:0] slot_r;
  logic [SLOT_W-1:0] meas_r;

  assign flip     = fall && (lr_s != lr_last);
  assign cur_slot = flip ? '0 : slot_r;
  assign half_len = (flip && synced_r) ? slot_r : meas_r;
  assign in_sync  = synced_r || flip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_last  <= 1'b0;
      synced_r <= 1'b0;
      slot_r   <= '0;
      meas_r   <= '0;
    end else begin
      if (fall) begin
        lr_last <= lr_s;
        slot_r  <= (cur_slot == SLOT_MAX) ? cur_slot : cur_slot + 1'b1;
      end
      if (flip) begin
        synced_r <= 1'b1;
        if (synced_r) meas_r <= slot_r;
      end
    end
  end

  AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> (slot_r == SLOT_W'(1))); // R3
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !flip |=> $stable(meas_r)); // R10

endmodule

// File: rtl/audtx_serial_tx.sv
module audtx_serial_tx #(
  parameter int SAMPLE_W = 32,
  parameter int SLOT_W   = 7,
  parameter int SYNC     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                lrclk,
  input  logic                fmt_i2s,
  input  logic [1:0]          wl_sel,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  output logic                sdout
);
  import audtx_pkg::*;

  localparam int IDX_W = $clog2(SAMPLE_W);

  logic                fall;
  logic                lr_s;
  logic                flip;
  logic                in_sync;
  logic [SLOT_W-1:0]   cur_slot;
  logic [SLOT_W-1:0]   half_len;
  logic                lr_is_left;
  logic                left_start;
  logic [SAMPLE_W-1:0] hold_l;
  logic [SAMPLE_W-1:0] hold_r;
  logic [SAMPLE_W-1:0] word;
  slot_pick_t          sel;
  logic [IDX_W-1:0]    bit_idx;
  logic                bit_now;
  logic                sdout_r;

  audtx_edge #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk),
    .fall(fall), .lr_s(lr_s)
  );

  audtx_frame #(.SLOT_W(SLOT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .fall(fall), .lr_s(lr_s),
    .flip(flip), .in_sync(in_sync), .cur_slot(cur_slot), .half_len(half_len)
  );

  // Left channel level depends on framing
  assign lr_is_left = (lr_s == ~fmt_i2s);
  assign left_start = flip && lr_is_left;
  assign word       = lr_is_left ? (left_start ? left_in : hold_l) : hold_r;
  assign sel        = pick_bit(fmt_i2s, int'(cur_slot), int'(half_len), wl_bits(wl_sel));
  assign bit_idx    = IDX_W'(sel.pos);
  assign bit_now    = in_sync && sel.act && word[bit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_l  <= '0;
      hold_r  <= '0;
      sdout_r <= 1'b0;
    end else begin
      if (left_start) begin
        hold_l <= left_in;
        hold_r <= right_in;
      end
      if (fall) sdout_r <= bit_now;
    end
  end

  assign sdout = sdout_r;

  AST_HOLD_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdout)); // R2
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !sel.act) |=> !sdout); // R8
  AST_UNSYNCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !in_sync) |=> !sdout); // R1
  AST_PAIR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !left_start |=> ($stable(hold_l) && $stable(hold_r))); // R9

endmodule

// File: tb/sim_audtx_serial_tx.sv
module sim_audtx_serial_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b1;
  logic        lrclk = 1'b0;
  logic        fmt_i2s = 1'b0;
  logic [1:0]  wl_sel = 2'd0;
  logic [31:0] left_in = '0;
  logic [31:0] right_in = '0;
  logic        sdout;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  logic        m_sync;
  int          m_cnt;
  int          m_n;
  logic [31:0] m_hl;
  logic [31:0] m_hr;

  always #5 clk = ~clk;

  audtx_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .fmt_i2s(fmt_i2s),
    .wl_sel(wl_sel), .left_in(left_in), .right_in(right_in), .sdout(sdout)
  );

  function automatic int wlen(input logic [1:0] c);
    return (c == 2'd3) ? 32 : 16 + 4 * int'(c);
  endfunction

  // expected bit, by the bit index each framing puts in slot s
  function automatic logic ref_bit(input logic i2s, input int wl, input int s,
                                   input int n, input logic [31:0] w);
    int k;
    if (i2s) begin
      if (s < 1 || s > wl) return 1'b0;
      k = wl - s;
    end else begin
      if (n < wl || s >= n) return 1'b0;
      k = n - 1 - s;
      if (k >= wl) return 1'b0;
    end
    return w[k];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    bclk  = 1'b1;
    lrclk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n  = 1'b1;
    m_sync = 1'b0;
    m_cnt  = 0;
    m_n    = 0;
    m_hl   = '0;
    m_hr   = '0;
    @(negedge clk);
  endtask

  // one LR half of n slots; optional input change at slot chg_at
  task automatic half(input logic lr_new, input int n, input string tag,
                      input int chg_at = -1, input logic [31:0] nl = '0,
                      input logic [31:0] nr = '0);
    logic        flp;
    logic        isleft;
    logic        prev;
    logic [63:0] got;
    logic [63:0] exp;
    int          unstable;
    flp      = (lr_new != lrclk);
    got      = '0;
    exp      = '0;
    unstable = 0;
    prev     = sdout;
    if (flp) begin
      if (m_sync) m_n = m_cnt;
      m_sync = 1'b1;
      m_cnt  = 0;
    end
    isleft = (lr_new == ~fmt_i2s);
    if (flp && isleft) begin
      m_hl = left_in;
      m_hr = right_in;
    end
    for (int s = 0; s < n; s++) begin
      if (s == chg_at) begin
        left_in  = nl;
        right_in = nr;
      end
      bclk   = 1'b0;
      lrclk  = lr_new;
      exp[s] = m_sync && ref_bit(fmt_i2s, wlen(wl_sel), m_cnt, m_n, isleft ? m_hl : m_hr);
      if (m_cnt < 127) m_cnt++;
      @(negedge clk);
      if (sdout !== prev) unstable++;
      repeat (5) @(negedge clk);
      got[s] = sdout;
      prev   = sdout;
      bclk   = 1'b1;
      repeat (6) @(negedge clk);
    end
    check(got === exp, tag, got, exp);
    check(unstable == 0, "R2 output moved before falling-edge update", 64'(unstable), 64'd0);
  endtask

  task automatic t_reset();
    do_reset();
    check(sdout === 1'b0, "R1 reset value", 64'(sdout), 64'd0);
    left_in  = 32'hFFFF_FFFF;
    right_in = 32'hFFFF_FFFF;
    fmt_i2s  = 1'b1;
    half(1'b0, 20, "R1 no output before first LR change");
  endtask

  task automatic t_i2s16();
    do_reset();
    fmt_i2s  = 1'b1;
    wl_sel   = 2'd0;
    left_in  = 32'h1234_A5C3;
    right_in = 32'h0000_8001;
    half(1'b0, 3, "R1 idle");
    half(1'b1, 32, "R4 right before any left capture");
    half(1'b0, 32, "R3 R7 R8 I2S left 16-bit");
    half(1'b1, 32, "R4 R8 I2S right 16-bit");
    left_in  = 32'h0000_7FFE;
    right_in = 32'hFFFF_0F0F;
    half(1'b0, 32, "R3 R4 I2S left new data");
    half(1'b1, 32, "R4 I2S right new data");
  endtask

  task automatic t_i2s_long();
    do_reset();
    fmt_i2s  = 1'b1;
    wl_sel   = 2'd2;
    left_in  = 32'h00C3_5A96;
    right_in = 32'h0081_7E01;
    half(1'b0, 2, "R1 idle");
    half(1'b1, 25, "R4 right");
    half(1'b0, 25, "R7 I2S 24-bit fills 25 slots");
    half(1'b1, 25, "R7 I2S 24-bit right");
    wl_sel   = 2'd3;
    left_in  = 32'h8000_0003;
    right_in = 32'hC001_0005;
    half(1'b0, 32, "R7 I2S 32-bit truncated in 32 slots");
    half(1'b1, 32, "R7 R4 I2S 32-bit right");
  endtask

  task automatic t_rj24();
    do_reset();
    fmt_i2s  = 1'b0;
    wl_sel   = 2'd2;
    left_in  = 32'h00A5_3C81;
    right_in = 32'h0012_34F7;
    half(1'b0, 3, "R1 idle");
    half(1'b1, 32, "R10 no count yet, low");
    half(1'b0, 32, "R5 R6 RJ right 24-bit");
    left_in  = 32'h00FF_0001;
    right_in = 32'h0080_0002;
    half(1'b1, 32, "R5 R6 RJ left 24-bit");
    half(1'b0, 32, "R5 R6 RJ right after new pair");
  endtask

  task automatic t_rj_edges();
    do_reset();
    fmt_i2s  = 1'b0;
    wl_sel   = 2'd1;
    left_in  = 32'h000F_0F0F;
    right_in = 32'h0008_0001;
    half(1'b0, 2, "R1 idle");
    half(1'b1, 20, "R10 first half low");
    half(1'b0, 20, "R5 RJ 20-bit MSB in slot 0");
    half(1'b1, 20, "R5 R6 RJ 20-bit left");
    wl_sel = 2'd3;
    half(1'b0, 24, "R10 RJ half shorter than word");
    half(1'b1, 24, "R10 RJ half shorter than word left");
    wl_sel = 2'd0;
    half(1'b0, 24, "R5 R7 RJ 16-bit in 24 slots");
  endtask

  task automatic t_coherence();
    do_reset();
    fmt_i2s  = 1'b1;
    wl_sel   = 2'd0;
    left_in  = 32'h0000_C0DE;
    right_in = 32'h0000_BEEF;
    half(1'b0, 3, "R1 idle");
    half(1'b1, 32, "R9 right before capture");
    half(1'b0, 32, "R9 left ignores mid-half change", 8, 32'h0000_1111, 32'h0000_2222);
    half(1'b1, 32, "R9 right keeps captured pair", 4, 32'h0000_3333, 32'h0000_4444);
    half(1'b0, 32, "R9 next left takes new pair");
    half(1'b1, 32, "R9 next right takes new pair");
  endtask

  initial begin
    t_reset();
    t_i2s16();
    t_i2s_long();
    t_rj24();
    t_rj_edges();
    t_coherence();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule